// File: doc/BRIEF.md
# Convergent Rounding Right Shifter

This unit scales a signed 32-bit integer down by a power of two and rounds the quotient to the nearest integer. When the discarded fraction is exactly one half, it picks the even neighbour. This is convergent rounding, and it avoids the drift that round-half-up builds up over long accumulations. Typical uses are requantising fixed-point products and dividing accumulators by a block size.

An operand and a shift count arrive together with a valid strobe. The rounded quotient leaves on a registered output one clock later, with a matching valid strobe. The operand is widened by sign extension before the rounding increment is added, so the sum cannot wrap at the top of the signed range. The increment is a plain half when the discarded bits are not at the tie boundary. When every bit below the half position is zero, the increment becomes the integer least significant bit moved into the half position, so ties land on the even result.

Top module: `cvg_rshift`

## Requirements
- R1: With a shift count of 0 the operand is returned unchanged.
- R2: When the discarded fraction is exactly one half, the result is the even one of the two neighbouring integers, for positive and negative operands alike.
- R3: When the discarded fraction is neither zero nor one half, the result is the nearest integer: the floor quotient when the fraction is below one half, the floor quotient plus one when it is above.
- R4: When the discarded bits are all zero, the result equals the exact arithmetic quotient.
- R5: No wrap occurs at the top of the range. 0x7FFFFFFF shifted by 1 gives 0x40000000, and shifted by 31 gives 1.
- R6: Negative operands follow the same rule. -6 shifted by 2 gives -2, -10 shifted by 2 gives -2, and 0x80000000 shifted by 31 gives -1 (0xFFFFFFFF).
- R7: `res_valid` is high exactly one cycle after each cycle in which `op_valid` is high. `res_data` changes only in the cycle after an accepted operand, and holds its value otherwise.
- R8: After reset, `res_valid` and `res_data` are both 0 until the first accepted operand.
- R9: The shift count is an unsigned 5-bit field, and every value from 0 to 31 follows R1 to R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operand and shift count are presented this cycle |
| op_data | input | 32 | Signed two's-complement operand |
| op_shift | input | 5 | Unsigned right-shift count, 0 to 31 |
| res_valid | output | 1 | Result is presented this cycle |
| res_data | output | 32 | Rounded signed quotient |

## Verification
Every shift count from 0 to 31 receives random full-range operands and random small signed values. Each result is classified by its discarded fraction (zero, exactly half, other), which keeps exact division, tie handling and ordinary nearest rounding apart. Directed ties are placed at even and odd integer parts on both signs. These show whether the increment really follows the integer LSB or is a fixed half. The extreme operands 0x7FFFFFFF and 0x80000000 at shifts 1 and 31 expose any wrap in the widened sum. Idle cycles with changed inputs show whether the output register respects the valid strobe.

// File: rtl/cvg_rshift_pkg.sv
package cvg_rshift_pkg;

  localparam int unsigned DATA_W  = 32;
  localparam int unsigned SHIFT_W = 5;

  // Mask with the lowest k bits set (k may be zero).
  function automatic logic [DATA_W-1:0] low_ones(input logic [SHIFT_W-1:0] k);
    low_ones = (DATA_W'(1) << k) - DATA_W'(1);
  endfunction

  // True when the bits strictly below the half position are all clear.
  // For n <= 1 there are no such bits, so the answer is true.
  function automatic logic below_half_clear(input logic [DATA_W-1:0] v,
                                            input logic [SHIFT_W-1:0] n);
    if (n <= SHIFT_W'(1)) below_half_clear = 1'b1;
    else below_half_clear = ((v & low_ones(n - SHIFT_W'(1))) == '0);
  endfunction

endpackage

// File: rtl/cvg_tie_detect.sv
module cvg_tie_detect
  import cvg_rshift_pkg::*;
#(
  parameter int unsigned W  = DATA_W,
  parameter int unsigned SW = SHIFT_W
) (
  input  logic [W-1:0]  operand,
  input  logic [SW-1:0] shift,
  output logic          tie_zone,
  output logic          int_lsb
);

  // tie_zone: every bit under the half position is zero, so the
  // fraction is either exactly zero or exactly one half.
  always_comb begin
    if (shift <= SW'(1)) tie_zone = 1'b1;
    else tie_zone = ((operand & ((W'(1) << (shift - SW'(1))) - W'(1))) == '0);
  end

  // Least significant bit of the integer part that survives the shift.
  assign int_lsb = operand[shift];

endmodule

// File: rtl/cvg_round_add.sv
module cvg_round_add #(
  parameter int unsigned W  = 32,
  parameter int unsigned SW = 5,
  parameter int unsigned EW = 2 * W
) (
  input  logic [W-1:0]  operand,
  input  logic [SW-1:0] shift,
  input  logic          tie_zone,
  input  logic          int_lsb,
  output logic [EW-1:0] round_inc,
  output logic [EW-1:0] wide_sum
);

  logic [EW-1:0] wide_op;
  logic [EW-1:0] half_unit;

  assign wide_op   = {{(EW-W){operand[W-1]}}, operand};
  assign half_unit = EW'(1) << (shift - SW'(1));

  always_comb begin
    if (shift == '0) round_inc = '0;
    else if (tie_zone) round_inc = int_lsb ? half_unit : '0;
    else round_inc = half_unit;
  end

  assign wide_sum = wide_op + round_inc;

endmodule

// File: rtl/cvg_arith_shift.sv
module cvg_arith_shift #(
  parameter int unsigned W  = 32,
  parameter int unsigned SW = 5,
  parameter int unsigned EW = 2 * W
) (
  input  logic [EW-1:0] wide_sum,
  input  logic [SW-1:0] shift,
  output logic [W-1:0]  quotient
);

  assign quotient = W'($signed(wide_sum) >>> shift);

endmodule

// File: rtl/cvg_rshift.sv
module cvg_rshift
  import cvg_rshift_pkg::*;
#(
  parameter int unsigned W  = DATA_W,
  parameter int unsigned SW = SHIFT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [W-1:0]  op_data,
  input  logic [SW-1:0] op_shift,
  output logic          res_valid,
  output logic [W-1:0]  res_data
);

  localparam int unsigned EW = 2 * W;

  logic          tie_zone;
  logic          int_lsb;
  logic [EW-1:0] round_inc;
  logic [EW-1:0] wide_sum;
  logic [W-1:0]  quotient;

  cvg_tie_detect #(.W(W), .SW(SW)) u_tie (
    .operand (op_data),
    .shift   (op_shift),
    .tie_zone(tie_zone),
    .int_lsb (int_lsb)
  );

  cvg_round_add #(.W(W), .SW(SW), .EW(EW)) u_add (
    .operand  (op_data),
    .shift    (op_shift),
    .tie_zone (tie_zone),
    .int_lsb  (int_lsb),
    .round_inc(round_inc),
    .wide_sum (wide_sum)
  );

  cvg_arith_shift #(.W(W), .SW(SW), .EW(EW)) u_shf (
    .wide_sum(wide_sum),
    .shift   (op_shift),
    .quotient(quotient)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= op_valid;
      if (op_valid) res_data <= quotient;
    end
  end

endmodule

// File: rtl/cvg_rshift_chk.sv
module cvg_rshift_chk #(
  parameter int unsigned W  = 32,
  parameter int unsigned SW = 5,
  parameter int unsigned EW = 2 * W
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_valid,
  input logic [W-1:0]  op_data,
  input logic [SW-1:0] op_shift,
  input logic          res_valid,
  input logic [W-1:0]  res_data,
  input logic [EW-1:0] round_inc
);

  logic [W-1:0]  frac_bits;
  logic [W-1:0]  half_w;
  logic [EW-1:0] half_e;
  logic [W-1:0]  exact_q;
  logic          is_tie;
  logic          is_exact;

  assign frac_bits = op_data & ((W'(1) << op_shift) - W'(1));
  assign half_w    = (op_shift == '0) ? '0 : (W'(1) << (op_shift - SW'(1)));
  assign half_e    = (op_shift == '0) ? '0 : (EW'(1) << (op_shift - SW'(1)));
  assign exact_q   = W'($signed(op_data) >>> op_shift);
  assign is_tie    = (op_shift != '0) && (frac_bits == half_w);
  assign is_exact  = (frac_bits == '0);

  p_valid_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid);
  p_valid_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !res_valid);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(res_data));
  p_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_shift == '0) |=> res_data == $past(op_data));
  p_tie_even_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && is_tie) |=> !res_data[0]);
  p_exact_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && is_exact) |=> res_data == $past(exact_q));
  p_inc_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> (round_inc == '0 || round_inc == half_e));

endmodule

bind cvg_rshift cvg_rshift_chk #(.W(W), .SW(SW), .EW(2 * W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_valid (op_valid),
  .op_data  (op_data),
  .op_shift (op_shift),
  .res_valid(res_valid),
  .res_data (res_data),
  .round_inc(round_inc)
);

// File: tb/cvg_rshift_test.sv
module cvg_rshift_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [31:0] op_data = '0;
  logic [4:0]  op_shift = '0;
  logic        res_valid;
  logic [31:0] res_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] last_exp = '0;

  always #5 clk = ~clk;

  cvg_rshift uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_data(op_data),
    .op_shift(op_shift), .res_valid(res_valid), .res_data(res_data)
  );

  // Floor quotient and remainder, then nearest with ties to even.
  function automatic logic [31:0] ref_round(input logic [31:0] x, input int n,
                                            output string tag);
    longint v, q, r, half;
    v = longint'($signed(x));
    if (n == 0) begin tag = "R1"; return x; end
    q = v >>> n;
    r = v - (q << n);
    half = 64'sd1 << (n - 1);
    if (r == 0) tag = "R4";
    else if (r == half) tag = "R2";
    else tag = "R3";
    if (r > half || (r == half && q[0])) q = q + 1;
    return q[31:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: present one operand and push its expected result.
  task automatic drive(input logic [31:0] x, input int n, input string force_tag);
    string t;
    logic [31:0] e;
    @(negedge clk);
    e = ref_round(x, n, t);
    if (force_tag != "") t = force_tag;
    op_valid = 1'b1;
    op_data  = x;
    op_shift = 5'(n);
    exp_q.push_back(e);
    tag_q.push_back({t, "/R9"});
  endtask

  task automatic idle();
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  // Monitor: pops and compares each result as it appears.
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (exp_q.size() == 0) begin
        check("R7", 32'd1, 32'd0);
      end else begin
        last_exp = exp_q.pop_front();
        check(tag_q.pop_front(), res_data, last_exp);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8", {31'd0, res_valid}, 32'd0);
    check("R8", res_data, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8", {31'd0, res_valid}, 32'd0);

    // Extremes and negative ties
    drive(32'h7FFFFFFF, 1, "R5");
    drive(32'h7FFFFFFF, 31, "R5");
    drive(32'hFFFFFFFA, 2, "R6");
    drive(32'hFFFFFFF6, 2, "R6");
    drive(32'h80000000, 31, "R6");
    drive(32'h80000000, 1, "R6");
    drive(32'h0000000A, 0, "R1");

    // Hold while idle: inputs change, output must not (R7)
    idle();
    op_data = 32'h12345678;
    op_shift = 5'd3;
    @(negedge clk);
    check("R7", {31'd0, res_valid}, 32'd0);
    check("R7", res_data, last_exp);
    @(negedge clk);
    check("R7", res_data, last_exp);

    // Every shift count: directed ties, then random operands (R9)
    for (int n = 0; n < 32; n++) begin
      if (n > 0) begin
        for (int k = -3; k <= 3; k++)
          drive(32'((longint'(k) <<< n) + (64'sd1 << (n - 1))), n, "");
      end
      for (int i = 0; i < 30; i++) drive($urandom(), n, "");
      for (int i = 0; i < 10; i++) drive(32'($signed($urandom_range(0, 400)) - 200), n, "");
      if (n % 4 == 0) idle();
    end

    idle();
    repeat (3) @(negedge clk);
    check("R7", 32'(exp_q.size()), 32'd0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule